// File: doc/BRIEF.md
# Video Memory Write Queue with Fill Drain

This block is a small circular write queue placed between a host data port and the on-chip video memories: a byte-wide video RAM, a colour RAM and a scroll RAM. Software first loads a command: a start address, a target memory, a DMA request bit and a DMA length. Each host data write after that takes the current address and target, goes into the queue, and moves the current address on by a programmable increment. The queue drains one entry for each pulse of the external access-slot strobe. The write strobes, address and data to the memories are combinational outputs that are valid during the slot cycle.

Byte-wide video RAM takes two slots per queued word, and the bytes go in a fixed order. A wide-memory configuration writes the whole word in one slot. The block also runs a fill-type DMA. The last queued value is replayed at the current address once per idle slot until the DMA length is used up. A host write during a non-fill DMA is held off, and a full queue stalls the host port.

Top module: `vmem_wq`

## Requirements
- R1: After a synchronous active-high reset, the queue is empty, `host_wr_ready` is 1, `dma_run` is 0 and no memory strobe is driven during a slot.
- R2: Target codes on `cmd_target` are 00 = video RAM, 01 = colour RAM, 10 = scroll RAM, and 11 = discard. A discarded entry uses one slot and produces no strobe. Each accepted host write stores the current address, then advances it by `addr_inc`, wrapping modulo 2^AW.
- R3: The queue holds DEPTH entries. While it is full, `host_wr_ready` is 0 and an offered write is not stored.
- R4: When `vram_128k` and `mode5` are not both 1, a video RAM entry takes two slots. The first slot writes data bits 7:0 to address XOR 1. The second slot writes data bits 15:8 to the address itself. Both writes carry the byte in `mem_data[7:0]` with `vram_word`=0, and the entry leaves the queue only after the second slot.
- R5: When `vram_128k` and `mode5` are both 1, a video RAM entry writes the full word at its address in one slot, with `vram_word`=1.
- R6: A colour RAM entry writes its word at its address in one slot. A scroll RAM entry writes its word in one slot at index (address/2) mod 64, driven on `mem_addr`.
- R7: At most one of the three strobes is high, and only during a slot. A slot with an empty queue and no running fill writes nothing.
- R8: `dma_kind` 10 selects fill and 11 selects copy. Loading a command with `cmd_dma_req`=1 and a non-fill kind sets `dma_run` at once. While that holds, `host_wr_ready` is 0. `ext_dma_done` clears it.
- R9: With `cmd_dma_req`=1 and fill selected, `dma_run` rises only when the queue drains to empty after the triggering host write has been written.
- R10: During a running fill, each slot that finds the queue empty replays the entry just before the write pointer at the current address. In byte mode this writes its bits 15:8 to current address XOR 1, or a full word in wide mode. The current address then advances by `addr_inc` and the length counts down. After the step that uses the last unit (length 1, or 0), `dma_run` falls and the fill is disarmed.
- R11: A fill step aimed at colour RAM or scroll RAM writes the word held in the queue slot at the write pointer, not the replayed entry's own word.
- R12: A host write accepted while a fill is armed clears `dma_run` on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_load | input | 1 | Load a new command |
| cmd_addr | input | AW | Start address of the command |
| cmd_target | input | 2 | Target memory code |
| cmd_dma_req | input | 1 | Command requests DMA |
| dma_kind | input | 2 | DMA kind selector |
| dma_len | input | LENW | DMA length loaded with the command |
| addr_inc | input | INCW | Address step per write or fill step |
| host_wr_valid | input | 1 | Host offers a data write |
| host_wr_data | input | 16 | Host data word |
| host_wr_ready | output | 1 | Host write can be accepted |
| vram_128k | input | 1 | Wide video RAM configuration bit |
| mode5 | input | 1 | Extended display mode bit |
| slot | input | 1 | External access slot strobe |
| ext_dma_done | input | 1 | Non-fill DMA finished |
| vram_we | output | 1 | Video RAM write strobe |
| vram_word | output | 1 | Video RAM write is a full word |
| cram_we | output | 1 | Colour RAM write strobe |
| vsram_we | output | 1 | Scroll RAM write strobe |
| mem_addr | output | AW | Memory write address or index |
| mem_data | output | 16 | Memory write data |
| dma_run | output | 1 | DMA running flag |

## Verification
The bench sweeps byte-mode addresses of both parities and checks the byte order. A design that swapped the halves, or popped the entry after one slot, would write the wrong byte to the wrong address, or only one byte. It fills the queue across an address wrap and offers a fifth write. A missing stall would show up as an extra write or a corrupted address. Fill runs are checked step by step for the replayed high byte, the advancing address, the stop when the length is used up, the cancel by a host write, and the colour-RAM case that takes its word from the write-pointer slot. A design that read the replayed entry's own word there would put the newer value on the bus.

// File: rtl/vwq_pkg.sv
package vwq_pkg;
  localparam int WORD_W = 16;

  typedef enum logic [1:0] {
    TGT_VRAM  = 2'b00,
    TGT_CRAM  = 2'b01,
    TGT_VSRAM = 2'b10,
    TGT_NONE  = 2'b11
  } tgt_e;

  function automatic logic kind_is_fill(input logic [1:0] kind);
    return kind == 2'b10;
  endfunction

  // second half of a split write carries the upper byte
  function automatic logic [7:0] pick_byte(input logic [WORD_W-1:0] d, input logic second);
    return second ? d[15:8] : d[7:0];
  endfunction

  function automatic logic [5:0] vsram_slot(input logic [6:0] a);
    return 6'(a >> 1);
  endfunction
endpackage

// File: rtl/vwq_ring.sv
module vwq_ring #(
  parameter int DEPTH = 4,
  parameter int AW    = 17,
  parameter int DW    = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [1:0]    push_tgt,
  input  logic [AW-1:0] push_addr,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  input  logic          head_split,
  input  logic          fill_take,
  input  logic [AW-1:0] fill_addr,
  output logic          empty,
  output logic          full,
  output logic          drains,
  output logic [1:0]    head_tgt,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data,
  output logic          head_part,
  output logic [1:0]    prev_tgt,
  output logic [DW-1:0] prev_data,
  output logic [DW-1:0] wrslot_data
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [1:0]    tgt_q  [DEPTH];
  logic [AW-1:0] addr_q [DEPTH];
  logic [DW-1:0] data_q [DEPTH];
  logic          part_q [DEPTH];
  logic [PW-1:0] rd, wr, rd_nx, wr_prev;
  logic          empty_q;

  assign rd_nx   = rd + 1'b1;
  assign wr_prev = wr - 1'b1;
  assign empty   = empty_q;
  assign full    = !empty_q && (rd == wr);
  assign drains  = pop && (rd_nx == wr);

  assign head_tgt    = tgt_q[rd];
  assign head_addr   = addr_q[rd];
  assign head_data   = data_q[rd];
  assign head_part   = part_q[rd];
  assign prev_tgt    = tgt_q[wr_prev];
  assign prev_data   = data_q[wr_prev];
  assign wrslot_data = data_q[wr];

  always_ff @(posedge clk) begin
    if (rst) begin
      rd      <= '0;
      wr      <= '0;
      empty_q <= 1'b1;
      for (int i = 0; i < DEPTH; i++) begin
        tgt_q[i]  <= '0;
        addr_q[i] <= '0;
        data_q[i] <= '0;
        part_q[i] <= 1'b0;
      end
    end else begin
      if (head_split) begin
        addr_q[rd] <= head_addr ^ AW'(1);
        part_q[rd] <= 1'b1;
      end
      if (fill_take) begin
        addr_q[wr_prev] <= fill_addr;
        part_q[wr_prev] <= 1'b1;
      end
      if (pop) rd <= rd_nx;
      if (drains) empty_q <= 1'b1;
      if (push) begin
        tgt_q[wr]  <= push_tgt;
        addr_q[wr] <= push_addr;
        data_q[wr] <= push_data;
        part_q[wr] <= 1'b0;
        wr         <= wr + 1'b1;
        if (empty_q || drains) rd <= wr;
        empty_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/vwq_fill_ctl.sv
module vwq_fill_ctl #(
  parameter int AW   = 17,
  parameter int LENW = 16,
  parameter int INCW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_load,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [1:0]      cmd_target,
  input  logic            cmd_dma_req,
  input  logic [1:0]      dma_kind,
  input  logic [LENW-1:0] dma_len,
  input  logic [INCW-1:0] addr_inc,
  input  logic            push,
  input  logic            queue_drains,
  input  logic            fill_step,
  input  logic            ext_dma_done,
  output logic [AW-1:0]   cur_addr,
  output logic [1:0]      cur_tgt,
  output logic            run,
  output logic            is_fill,
  output logic            armed
);
  import vwq_pkg::*;

  logic [AW-1:0]   addr_q;
  logic [1:0]      tgt_q;
  logic            req_q;
  logic [LENW-1:0] len_q;
  logic            last_unit;

  assign is_fill   = kind_is_fill(dma_kind);
  assign armed     = req_q && is_fill;
  assign last_unit = len_q <= LENW'(1);
  assign cur_addr  = addr_q;
  assign cur_tgt   = tgt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      tgt_q  <= '0;
      req_q  <= 1'b0;
      len_q  <= '0;
      run    <= 1'b0;
    end else begin
      if (queue_drains && armed) run <= 1'b1;
      if (fill_step && last_unit) run <= 1'b0;
      if (push && armed) run <= 1'b0;
      if (ext_dma_done && !is_fill) run <= 1'b0;
      if (cmd_load) begin
        addr_q <= cmd_addr;
        tgt_q  <= cmd_target;
        req_q  <= cmd_dma_req;
        len_q  <= dma_len;
        run    <= cmd_dma_req && !is_fill;
      end else begin
        if (push || fill_step) addr_q <= addr_q + AW'(addr_inc);
        if (fill_step) begin
          len_q <= len_q - LENW'(1);
          if (last_unit) req_q <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/vmem_wq.sv
module vmem_wq #(
  parameter int DEPTH = 4,
  parameter int AW    = 17,
  parameter int LENW  = 16,
  parameter int INCW  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cmd_load,
  input  logic [AW-1:0]   cmd_addr,
  input  logic [1:0]      cmd_target,
  input  logic            cmd_dma_req,
  input  logic [1:0]      dma_kind,
  input  logic [LENW-1:0] dma_len,
  input  logic [INCW-1:0] addr_inc,
  input  logic            host_wr_valid,
  input  logic [15:0]     host_wr_data,
  output logic            host_wr_ready,
  input  logic            vram_128k,
  input  logic            mode5,
  input  logic            slot,
  input  logic            ext_dma_done,
  output logic            vram_we,
  output logic            vram_word,
  output logic            cram_we,
  output logic            vsram_we,
  output logic [AW-1:0]   mem_addr,
  output logic [15:0]     mem_data,
  output logic            dma_run
);
  import vwq_pkg::*;

  logic          q_empty, q_full, q_drains;
  logic [1:0]    head_tgt, prev_tgt, cur_tgt;
  logic [AW-1:0] head_addr, cur_addr;
  logic [15:0]   head_data, prev_data, wrslot_data;
  logic          head_part;
  logic          run, is_fill, armed;
  logic          accept, drain, fill_step, pop_evt, split_evt;
  logic          nonfill_busy, armed_push, wide;
  logic [1:0]    e_tgt;
  logic [AW-1:0] e_addr;
  logic [15:0]   e_data;
  logic          e_part;

  assign nonfill_busy  = run && !is_fill;
  assign host_wr_ready = !q_full && !nonfill_busy;
  assign accept        = host_wr_valid && host_wr_ready;
  assign armed_push    = accept && armed;
  assign drain         = slot && !q_empty;
  assign fill_step     = slot && q_empty && run && is_fill;
  assign wide          = vram_128k && mode5;
  assign dma_run       = run;

  assign e_tgt  = fill_step ? prev_tgt  : head_tgt;
  assign e_addr = fill_step ? cur_addr  : head_addr;
  assign e_data = fill_step ? prev_data : head_data;
  assign e_part = fill_step ? 1'b1      : head_part;

  always_comb begin
    vram_we   = 1'b0;
    vram_word = 1'b0;
    cram_we   = 1'b0;
    vsram_we  = 1'b0;
    mem_addr  = '0;
    mem_data  = '0;
    pop_evt   = 1'b0;
    split_evt = 1'b0;
    if (drain || fill_step) begin
      unique case (tgt_e'(e_tgt))
        TGT_VRAM: begin
          vram_we = 1'b1;
          if (wide) begin
            vram_word = 1'b1;
            mem_addr  = e_addr;
            mem_data  = e_data;
            pop_evt   = drain;
          end else begin
            mem_addr  = e_addr ^ AW'(1);
            mem_data  = {8'h00, pick_byte(e_data, e_part)};
            split_evt = drain && !e_part;
            pop_evt   = drain && e_part;
          end
        end
        TGT_CRAM: begin
          cram_we  = 1'b1;
          mem_addr = e_addr;
          mem_data = e_part ? wrslot_data : e_data;
          pop_evt  = drain;
        end
        TGT_VSRAM: begin
          vsram_we = 1'b1;
          mem_addr = AW'(vsram_slot(e_addr[6:0]));
          mem_data = e_part ? wrslot_data : e_data;
          pop_evt  = drain;
        end
        default: pop_evt = drain;
      endcase
    end
  end

  vwq_ring #(.DEPTH(DEPTH), .AW(AW), .DW(16)) u_ring (
    .clk(clk), .rst(rst),
    .push(accept), .push_tgt(cur_tgt), .push_addr(cur_addr), .push_data(host_wr_data),
    .pop(pop_evt), .head_split(split_evt), .fill_take(fill_step), .fill_addr(cur_addr),
    .empty(q_empty), .full(q_full), .drains(q_drains),
    .head_tgt(head_tgt), .head_addr(head_addr), .head_data(head_data), .head_part(head_part),
    .prev_tgt(prev_tgt), .prev_data(prev_data), .wrslot_data(wrslot_data)
  );

  vwq_fill_ctl #(.AW(AW), .LENW(LENW), .INCW(INCW)) u_fill (
    .clk(clk), .rst(rst),
    .cmd_load(cmd_load), .cmd_addr(cmd_addr), .cmd_target(cmd_target),
    .cmd_dma_req(cmd_dma_req), .dma_kind(dma_kind), .dma_len(dma_len), .addr_inc(addr_inc),
    .push(accept), .queue_drains(q_drains), .fill_step(fill_step), .ext_dma_done(ext_dma_done),
    .cur_addr(cur_addr), .cur_tgt(cur_tgt), .run(run), .is_fill(is_fill), .armed(armed)
  );
endmodule

// File: rtl/vmem_wq_chk.sv
module vmem_wq_chk (
  input logic clk,
  input logic rst,
  input logic slot,
  input logic vram_we,
  input logic vram_word,
  input logic cram_we,
  input logic vsram_we,
  input logic vram_128k,
  input logic mode5,
  input logic host_wr_ready,
  input logic dma_run,
  input logic q_full,
  input logic q_empty,
  input logic split_evt,
  input logic armed_push
);
  p_one_strobe_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({vram_we, cram_we, vsram_we}));

  p_idle_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    !slot |-> !(vram_we || cram_we || vsram_we));

  p_full_stall_r3: assert property (@(posedge clk) disable iff (rst)
    q_full |-> !host_wr_ready);

  p_split_keeps_entry_r4: assert property (@(posedge clk) disable iff (rst)
    split_evt |=> !q_empty);

  p_wide_word_r5: assert property (@(posedge clk) disable iff (rst)
    (vram_we && vram_128k && mode5) |-> vram_word);

  p_byte_mode_r4: assert property (@(posedge clk) disable iff (rst)
    (vram_we && !(vram_128k && mode5)) |-> !vram_word);

  p_fill_cancel_r12: assert property (@(posedge clk) disable iff (rst)
    armed_push |=> !dma_run);
endmodule

bind vmem_wq vmem_wq_chk u_chk (
  .clk(clk), .rst(rst), .slot(slot),
  .vram_we(vram_we), .vram_word(vram_word), .cram_we(cram_we), .vsram_we(vsram_we),
  .vram_128k(vram_128k), .mode5(mode5), .host_wr_ready(host_wr_ready), .dma_run(dma_run),
  .q_full(q_full), .q_empty(q_empty), .split_evt(split_evt), .armed_push(armed_push)
);

// File: tb/tb_vmem_wq.sv
`timescale 1ns/100ps
module tb_vmem_wq;
  localparam int AW = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_load = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [1:0] cmd_target = '0;
  logic cmd_dma_req = 1'b0;
  logic [1:0] dma_kind = '0;
  logic [15:0] dma_len = '0;
  logic [7:0] addr_inc = '0;
  logic host_wr_valid = 1'b0;
  logic [15:0] host_wr_data = '0;
  logic host_wr_ready;
  logic vram_128k = 1'b0, mode5 = 1'b0, slot = 1'b0, ext_dma_done = 1'b0;
  logic vram_we, vram_word, cram_we, vsram_we, dma_run;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  vmem_wq dut (
    .clk(clk), .rst(rst), .cmd_load(cmd_load), .cmd_addr(cmd_addr), .cmd_target(cmd_target),
    .cmd_dma_req(cmd_dma_req), .dma_kind(dma_kind), .dma_len(dma_len), .addr_inc(addr_inc),
    .host_wr_valid(host_wr_valid), .host_wr_data(host_wr_data), .host_wr_ready(host_wr_ready),
    .vram_128k(vram_128k), .mode5(mode5), .slot(slot), .ext_dma_done(ext_dma_done),
    .vram_we(vram_we), .vram_word(vram_word), .cram_we(cram_we), .vsram_we(vsram_we),
    .mem_addr(mem_addr), .mem_data(mem_data), .dma_run(dma_run)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cmd_load = 0; host_wr_valid = 0; slot = 0; ext_dma_done = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic load(input logic [AW-1:0] a, input logic [1:0] t, input logic req,
                      input logic [15:0] len);
    cmd_addr = a; cmd_target = t; cmd_dma_req = req; dma_len = len; cmd_load = 1'b1;
    @(negedge clk);
    cmd_load = 1'b0;
  endtask

  task automatic push(input logic [15:0] d);
    host_wr_data = d; host_wr_valid = 1'b1;
    @(negedge clk);
    host_wr_valid = 1'b0;
  endtask

  // strobes {vram, word, cram, vsram}, then address, then data
  task automatic slot_expect(input string tag, input logic [3:0] st,
                             input logic [AW-1:0] a, input logic [15:0] d);
    slot = 1'b1;
    #1;
    check(tag, {27'd0, vram_we, vram_word, cram_we, vsram_we, mem_addr, mem_data},
               {27'd0, st, a, d});
    @(negedge clk);
    slot = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R1 reset state
    check("R1 ready after reset", host_wr_ready, 1);
    check("R1 dma_run after reset", dma_run, 0);
    slot_expect("R1 R7 empty slot writes nothing", 4'b0000, '0, '0);

    // R4 byte order sweep over address parities
    addr_inc = 8'd2;
    for (int i = 0; i < 6; i++) begin
      logic [AW-1:0] a;
      logic [15:0] d;
      a = AW'(i * 44857 + i);
      d = 16'(16'h1234 + i * 16'h1111);
      load(a, 2'b00, 1'b0, 16'd0);
      push(d);
      slot_expect("R4 first slot low byte to addr^1", 4'b1000, a ^ AW'(1), {8'h00, d[7:0]});
      slot_expect("R4 second slot high byte to addr", 4'b1000, a, {8'h00, d[15:8]});
      slot_expect("R4 entry gone after two slots", 4'b0000, '0, '0);
    end

    // R5 wide configuration only when both bits set
    for (int m = 0; m < 4; m++) begin
      logic [AW-1:0] a;
      a = AW'(17'h00300 + m * 16'h0105);
      vram_128k = m[0]; mode5 = m[1];
      load(a, 2'b00, 1'b0, 16'd0);
      push(16'hBEEF);
      if (m == 3) begin
        slot_expect("R5 wide word single slot", 4'b1100, a, 16'hBEEF);
      end else begin
        slot_expect("R5 R4 byte mode when not both bits", 4'b1000, a ^ AW'(1), 16'h00EF);
        slot_expect("R5 R4 byte mode second half", 4'b1000, a, 16'h00BE);
      end
      slot_expect("R5 nothing left", 4'b0000, '0, '0);
    end

    // R2 R3 increment with wrap, full stall
    do_reset();
    vram_128k = 1; mode5 = 1; addr_inc = 8'd3;
    load(17'h1FFFE, 2'b00, 1'b0, 16'd0);
    for (int i = 0; i < 4; i++) push(16'(16'h0A00 + i));
    check("R3 ready low when full", host_wr_ready, 0);
    push(16'hDEAD);
    for (int i = 0; i < 4; i++)
      slot_expect("R2 R3 stored address steps by increment with wrap", 4'b1100,
                  AW'(17'h1FFFE + 3 * i), 16'(16'h0A00 + i));
    slot_expect("R3 write offered while full was not stored", 4'b0000, '0, '0);
    check("R3 ready back after drain", host_wr_ready, 1);

    // R6 colour and scroll RAM, R2 discard code
    vram_128k = 0; mode5 = 0; addr_inc = 8'd2;
    load(17'h0004A, 2'b01, 1'b0, 16'd0);
    push(16'h0E2C);
    slot_expect("R6 colour RAM word", 4'b0010, 17'h0004A, 16'h0E2C);
    load(17'h1237B, 2'b10, 1'b0, 16'd0);
    push(16'h03F1);
    slot_expect("R6 scroll RAM index", 4'b0001, AW'((17'h1237B / 2) % 64), 16'h03F1);
    load(17'h00100, 2'b11, 1'b0, 16'd0);
    push(16'h7777);
    slot_expect("R2 discard code writes nothing", 4'b0000, '0, '0);
    slot_expect("R2 discard entry used its slot", 4'b0000, '0, '0);

    // R9 R10 fill in byte mode
    do_reset();
    dma_kind = 2'b10; addr_inc = 8'd1;
    load(17'h00200, 2'b00, 1'b1, 16'd3);
    check("R9 fill not running before data write", dma_run, 0);
    push(16'hA5C3);
    slot_expect("R9 trigger low byte", 4'b1000, 17'h00201, 16'h00C3);
    check("R9 fill waits for trigger to finish", dma_run, 0);
    slot_expect("R9 trigger high byte", 4'b1000, 17'h00200, 16'h00A5);
    check("R9 fill starts after drain", dma_run, 1);
    for (int i = 1; i <= 3; i++)
      slot_expect("R10 fill step high byte at cur^1", 4'b1000,
                  AW'(17'h00200 + i) ^ AW'(1), 16'h00A5);
    check("R10 fill stops after length", dma_run, 0);
    slot_expect("R10 no write after fill end", 4'b0000, '0, '0);

    // R12 host write cancels running fill
    do_reset();
    dma_kind = 2'b10; addr_inc = 8'd1;
    load(17'h00200, 2'b00, 1'b1, 16'd10);
    push(16'h1122);
    slot_expect("R12 setup low", 4'b1000, 17'h00201, 16'h0022);
    slot_expect("R12 setup high", 4'b1000, 17'h00200, 16'h0011);
    slot_expect("R10 one fill step", 4'b1000, 17'h00200, 16'h0011);
    check("R12 fill running", dma_run, 1);
    push(16'h0F3C);
    check("R12 host write clears run", dma_run, 0);
    slot_expect("R12 new entry low byte", 4'b1000, 17'h00203, 16'h003C);

    // R8 non-fill DMA blocks host writes
    do_reset();
    dma_kind = 2'b11;
    load(17'h00040, 2'b00, 1'b1, 16'd4);
    check("R8 copy sets run at load", dma_run, 1);
    check("R8 ready low during copy", host_wr_ready, 0);
    push(16'h4444);
    slot_expect("R8 rejected write not stored", 4'b0000, '0, '0);
    ext_dma_done = 1'b1;
    @(negedge clk);
    ext_dma_done = 1'b0;
    check("R8 done clears run", dma_run, 0);
    check("R8 ready after done", host_wr_ready, 1);

    // R11 colour RAM fill takes word at write-pointer slot
    do_reset();
    dma_kind = 2'b00; addr_inc = 8'd2;
    load(17'h00000, 2'b01, 1'b0, 16'd0);
    for (int i = 1; i <= 4; i++) push(16'(i * 16'h0111));
    for (int i = 0; i < 4; i++)
      slot_expect("R6 colour RAM sequence", 4'b0010, AW'(2 * i), 16'((i + 1) * 16'h0111));
    dma_kind = 2'b10;
    load(17'h00020, 2'b01, 1'b1, 16'd1);
    push(16'h0555);
    slot_expect("R11 trigger write", 4'b0010, 17'h00020, 16'h0555);
    check("R9 colour fill armed", dma_run, 1);
    slot_expect("R11 fill uses write-pointer slot word", 4'b0010, 17'h00022, 16'h0222);
    check("R10 length one ends fill", dma_run, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule